// File: doc/BRIEF.md
# PTP Target Time Pulse Trigger

This block keeps a programmable target time, made of a seconds value and a nanoseconds value, that software writes through a small register port clocked by the register clock. A start or stop command captures the target into a holding register. A toggle handshake then carries it into the PTP clock domain. While the transfer is in flight, a busy flag is raised and further target writes are refused, so the value in transit cannot be torn.

In the PTP domain the armed target is compared against the running timestamp. The timestamp advances in steps of the sub-second increment, so the comparison fires when the time has reached or passed the target, not only on exact equality. When it fires, the pulse output is driven high for a start command or low for a stop command. The firing is also returned to the register domain as a sticky status bit, which drives the interrupt output when enabled. Each command arms exactly one firing.

Register map (word address on `addr`): 0 is the seconds target; 1 holds the nanoseconds target in bits 30:0 and the read-only busy flag in bit 31; 2 holds the interrupt enable in bit 0 and the sticky match status in bit 1 (write 1 to clear).

Top module: `pps_target_trigger`

## Requirements
- R1: After reset all three registers read 0, the busy flag is 0, `ppsOut` is 0 and `irq` is 0.
- R2: A command pulse with `cmd` equal to 3'b010 or 3'b011 while not busy sets the busy flag (address 1 bit 31) on the next register clock edge. The flag clears by itself once the target has been taken into the PTP domain.
- R3: Writes to address 0 or address 1 made while busy reads 1 leave both target values unchanged.
- R4: Command codes other than 3'b010 and 3'b011 are ignored: busy stays 0 and the pulse output does not change.
- R5: A write to address 1 whose bits 30:0 exceed 999,999,999 is ignored. A value of exactly 999,999,999 is accepted.
- R6: An armed target fires on the first timestamp that has reached or passed it: seconds greater, or seconds equal and nanoseconds greater or equal. `ppsOut` takes its new value on the PTP clock edge that samples that timestamp.
- R7: Firing under command 3'b010 drives `ppsOut` to 1; firing under command 3'b011 drives it to 0.
- R8: A target fires once per accepted command; it does not fire again while the time stays past it.
- R9: A firing sets the sticky status (address 2 bit 1); writing address 2 with bit 1 set clears it; `irq` is the status ANDed with the enable (address 2 bit 0).
- R10: Address 0 reads back the seconds target, address 1 the nanoseconds target with busy in bit 31, and address 2 the status and enable bits, as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Register domain clock |
| regRstN | input | 1 | Register domain reset, active low |
| ptpClk | input | 1 | PTP domain clock |
| ptpRstN | input | 1 | PTP domain reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word address for write and read |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `addr` |
| cmdValid | input | 1 | Command strobe |
| cmd | input | 3 | Command code: 3'b010 start, 3'b011 stop |
| ptpSec | input | 32 | Running timestamp, seconds |
| ptpNs | input | 31 | Running timestamp, nanoseconds |
| ppsOut | output | 1 | Pulse output level |
| irq | output | 1 | Interrupt request |

## Verification
A handshake toggle that is lost or doubled shows up as a busy flag that never clears, or that clears before arming. In either case the pulse output then misses its target edge, and this is visible within a few hundred PTP cycles. A wrong comparison direction or an exact-equality compare shows up at the ports as an edge that comes early, or an edge that never comes when the timestamp steps over the target. The bench therefore checks which timestamp sample produced each edge. A lost single-shot disarm, or a sticky status that cannot be cleared, brings the status bit back after it has been cleared, and this can be read back a few register cycles later.

// File: rtl/pps_trig_pkg.sv
`timescale 1ns/1ps
package pps_trig_pkg;
  // register-domain strobes from control to datapath
  typedef struct packed {
    logic ldSec;
    logic ldNs;
    logic capture;
  } regStrobe_t;

  // PTP-domain strobes from control to datapath
  typedef struct packed {
    logic load;
    logic fire;
  } ptpStrobe_t;

  localparam logic [2:0] CMD_START = 3'b010;
  localparam logic [2:0] CMD_STOP  = 3'b011;
endpackage

// File: rtl/pps_trig_sync.sv
`timescale 1ns/1ps
module pps_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pps_trig_ctrl.sv
`timescale 1ns/1ps
module pps_trig_ctrl
  import pps_trig_pkg::*;
#(
  parameter int NS_W        = 31,
  parameter int NS_MAX      = 999999999,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = NS_W + 1
) (
  input  logic          regClk,
  input  logic          regRstN,
  input  logic          ptpClk,
  input  logic          ptpRstN,
  input  logic          wrEn,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  input  logic          cmdValid,
  input  logic [2:0]    cmd,
  input  logic          reached,
  output regStrobe_t    regStb,
  output ptpStrobe_t    ptpStb,
  output logic          busy,
  output logic          armed,
  output logic          sticky,
  output logic          irqEn
);
  localparam logic [NS_W-1:0] NS_LIM = NS_W'(NS_MAX);

  // register domain
  logic reqTog, ackSync, hitSync, hitSeen, hitEdge, cmdOk, wrOpen, wrCtl;
  // PTP domain
  logic reqSync, reqSeen, hitTog;

  assign wrOpen  = wrEn && !busy;
  assign cmdOk   = cmdValid && !busy && (cmd == CMD_START || cmd == CMD_STOP);
  assign wrCtl   = wrEn && addr == 2'd2;
  assign hitEdge = hitSync != hitSeen;

  always_comb begin
    regStb         = '0;
    regStb.ldSec   = wrOpen && addr == 2'd0;
    regStb.ldNs    = wrOpen && addr == 2'd1 && wrData[NS_W-1:0] <= NS_LIM;
    regStb.capture = cmdOk;
  end

  always_ff @(posedge regClk or negedge regRstN) begin
    if (!regRstN) begin
      busy    <= 1'b0;
      reqTog  <= 1'b0;
      hitSeen <= 1'b0;
      sticky  <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (cmdOk) begin
        busy   <= 1'b1;
        reqTog <= ~reqTog;
      end else if (busy && ackSync == reqTog) begin
        busy <= 1'b0;
      end
      hitSeen <= hitSync;
      if (hitEdge)                 sticky <= 1'b1;
      else if (wrCtl && wrData[1]) sticky <= 1'b0;
      if (wrCtl) irqEn <= wrData[0];
    end
  end

  pps_trig_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(regClk), .rstN(regRstN), .d(reqSeen), .q(ackSync));
  pps_trig_sync #(.STAGES(SYNC_STAGES)) u_hitSync (
    .clk(regClk), .rstN(regRstN), .d(hitTog), .q(hitSync));
  pps_trig_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(ptpClk), .rstN(ptpRstN), .d(reqTog), .q(reqSync));

  always_comb begin
    ptpStb      = '0;
    ptpStb.load = reqSync != reqSeen;
    ptpStb.fire = armed && reached && !ptpStb.load;
  end

  always_ff @(posedge ptpClk or negedge ptpRstN) begin
    if (!ptpRstN) begin
      reqSeen <= 1'b0;
      armed   <= 1'b0;
      hitTog  <= 1'b0;
    end else begin
      reqSeen <= reqSync;
      if (ptpStb.load)      armed <= 1'b1;
      else if (ptpStb.fire) armed <= 1'b0;
      if (ptpStb.fire) hitTog <= ~hitTog;
    end
  end
endmodule

// File: rtl/pps_trig_dp.sv
`timescale 1ns/1ps
module pps_trig_dp
  import pps_trig_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 31,
  localparam int DW   = NS_W + 1
) (
  input  logic             regClk,
  input  logic             regRstN,
  input  logic             ptpClk,
  input  logic             ptpRstN,
  input  logic [DW-1:0]    wrData,
  input  logic             cmdStop,
  input  regStrobe_t       regStb,
  input  ptpStrobe_t       ptpStb,
  input  logic [SEC_W-1:0] ptpSec,
  input  logic [NS_W-1:0]  ptpNs,
  output logic [SEC_W-1:0] secTgt,
  output logic [NS_W-1:0]  nsTgt,
  output logic             reached,
  output logic             ppsOut
);
  logic [SEC_W-1:0] holdSec, actSec;
  logic [NS_W-1:0]  holdNs, actNs;
  logic             holdStop, actStop;

  always_ff @(posedge regClk or negedge regRstN) begin
    if (!regRstN) begin
      secTgt   <= '0;
      nsTgt    <= '0;
      holdSec  <= '0;
      holdNs   <= '0;
      holdStop <= 1'b0;
    end else begin
      if (regStb.ldSec) secTgt <= wrData[SEC_W-1:0];
      if (regStb.ldNs)  nsTgt  <= wrData[NS_W-1:0];
      if (regStb.capture) begin
        holdSec  <= secTgt;
        holdNs   <= nsTgt;
        holdStop <= cmdStop;
      end
    end
  end

  // holding registers are stable while the request toggle is in flight
  always_ff @(posedge ptpClk or negedge ptpRstN) begin
    if (!ptpRstN) begin
      actSec  <= '0;
      actNs   <= '0;
      actStop <= 1'b0;
      ppsOut  <= 1'b0;
    end else begin
      if (ptpStb.load) begin
        actSec  <= holdSec;
        actNs   <= holdNs;
        actStop <= holdStop;
      end
      if (ptpStb.fire) ppsOut <= !actStop;
    end
  end

  assign reached = (ptpSec > actSec) || (ptpSec == actSec && ptpNs >= actNs);
endmodule

// File: rtl/pps_target_trigger.sv
`timescale 1ns/1ps
module pps_target_trigger
  import pps_trig_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int NS_W        = 31,
  parameter int NS_MAX      = 999999999,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = NS_W + 1
) (
  input  logic             regClk,
  input  logic             regRstN,
  input  logic             ptpClk,
  input  logic             ptpRstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  input  logic             cmdValid,
  input  logic [2:0]       cmd,
  input  logic [SEC_W-1:0] ptpSec,
  input  logic [NS_W-1:0]  ptpNs,
  output logic             ppsOut,
  output logic             irq
);
  regStrobe_t       regStb;
  ptpStrobe_t       ptpStb;
  logic             busy, armed, sticky, irqEn, reached;
  logic [SEC_W-1:0] secTgt;
  logic [NS_W-1:0]  nsTgt;

  pps_trig_ctrl #(.NS_W(NS_W), .NS_MAX(NS_MAX), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .regClk(regClk), .regRstN(regRstN), .ptpClk(ptpClk), .ptpRstN(ptpRstN),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cmdValid(cmdValid), .cmd(cmd),
    .reached(reached), .regStb(regStb), .ptpStb(ptpStb), .busy(busy),
    .armed(armed), .sticky(sticky), .irqEn(irqEn));

  pps_trig_dp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_dp (
    .regClk(regClk), .regRstN(regRstN), .ptpClk(ptpClk), .ptpRstN(ptpRstN),
    .wrData(wrData), .cmdStop(cmd[0]), .regStb(regStb), .ptpStb(ptpStb),
    .ptpSec(ptpSec), .ptpNs(ptpNs), .secTgt(secTgt), .nsTgt(nsTgt),
    .reached(reached), .ppsOut(ppsOut));

  always_comb begin
    case (addr)
      2'd0:    rdData = DW'(secTgt);
      2'd1:    rdData = {busy, nsTgt};
      2'd2:    rdData = {{(DW-2){1'b0}}, sticky, irqEn};
      default: rdData = '0;
    endcase
  end

  assign irq = sticky && irqEn;
endmodule

// File: rtl/pps_trig_checker.sv
`timescale 1ns/1ps
module pps_trig_checker #(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 31,
  parameter int NS_MAX = 999999999
) (
  input logic             regClk,
  input logic             regRstN,
  input logic             ptpClk,
  input logic             ptpRstN,
  input logic             cmdValid,
  input logic [2:0]       cmd,
  input logic             busy,
  input logic [SEC_W-1:0] secTgt,
  input logic [NS_W-1:0]  nsTgt,
  input logic             armed,
  input logic             ppsOut
);
  assert_busy_on_cmd_R2: assert property (@(posedge regClk) disable iff (!regRstN)
    (cmdValid && !busy && (cmd == 3'b010 || cmd == 3'b011)) |=> busy);

  assert_target_frozen_R3: assert property (@(posedge regClk) disable iff (!regRstN)
    busy |=> ($stable(secTgt) && $stable(nsTgt)));

  assert_ns_in_range_R5: assert property (@(posedge regClk) disable iff (!regRstN)
    nsTgt <= NS_W'(NS_MAX));

  assert_pps_from_armed_R8: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    !$stable(ppsOut) |-> $past(armed));

  assert_disarm_after_edge_R8: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    !$stable(ppsOut) |-> !armed);
endmodule

bind pps_target_trigger pps_trig_checker #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_MAX(NS_MAX)) u_chk (
  .regClk(regClk), .regRstN(regRstN), .ptpClk(ptpClk), .ptpRstN(ptpRstN),
  .cmdValid(cmdValid), .cmd(cmd), .busy(busy), .secTgt(secTgt), .nsTgt(nsTgt),
  .armed(armed), .ppsOut(ppsOut));

// File: tb/test_pps_target_trigger.sv
`timescale 1ns/1ps
module test_pps_target_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int PTP_PERIOD = 14;
  localparam longint INC    = 7;
  localparam longint GIGA   = 64'd1000000000;

  logic        regClk = 0, ptpClk = 0, regRstN = 0, ptpRstN = 0;
  logic        wrEn = 0, cmdValid = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic [2:0]  cmd = 0;
  logic [31:0] ptpSec;
  logic [30:0] ptpNs;
  logic        ppsOut, irq;

  longint      total = 0, loadVal = 0;
  logic        loadEn = 0;
  int          testCnt = 0, failCnt = 0;
  logic        monOn = 0, lastPps = 0;

  typedef struct { logic level; longint tgt; logic win; string req; } expItem_t;
  expItem_t    expQ[$];

  always #(CLK_PERIOD/2) regClk = ~regClk;
  always #(PTP_PERIOD/2) ptpClk = ~ptpClk;

  always @(posedge ptpClk) total <= loadEn ? loadVal : total + INC;
  assign ptpSec = 32'(total / GIGA);
  assign ptpNs  = 31'(total % GIGA);

  pps_target_trigger i_pps_target_trigger (
    .regClk(regClk), .regRstN(regRstN), .ptpClk(ptpClk), .ptpRstN(ptpRstN),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .cmdValid(cmdValid), .cmd(cmd), .ptpSec(ptpSec), .ptpNs(ptpNs),
    .ppsOut(ppsOut), .irq(irq));

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge regClk); wrEn = 1; addr = a; wrData = d;
    @(negedge regClk); wrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge regClk); addr = a; #1; d = rdData;
  endtask

  task automatic issueCmd(input logic [2:0] c);
    @(negedge regClk); cmdValid = 1; cmd = c;
    @(negedge regClk); cmdValid = 0;
  endtask

  task automatic setTime(input longint t);
    @(negedge ptpClk); loadVal = t; loadEn = 1;
    @(negedge ptpClk); loadEn = 0;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] d;
    d = 32'h8000_0000;
    for (int i = 0; i < 60 && d[31]; i++) regRead(2'd1, d);
    check(!d[31], req, longint'(d[31]), 0);
  endtask

  task automatic expectEdge(input logic lvl, input longint tgt, input logic win, input string req);
    expItem_t it;
    it.level = lvl; it.tgt = tgt; it.win = win; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitPps(input logic lvl, input int maxCyc, input string req);
    for (int i = 0; i < maxCyc && ppsOut !== lvl; i++) @(negedge regClk);
    check(ppsOut === lvl, req, longint'(ppsOut), longint'(lvl));
  endtask

  // monitor: every output edge must match the next expected item
  always @(negedge ptpClk) begin
    if (monOn && ppsOut !== lastPps) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected edge", longint'(ppsOut), longint'(lastPps));
      end else begin
        expItem_t it;
        longint trig;
        it = expQ.pop_front();
        trig = total - INC;
        check(ppsOut === it.level, {it.req, " level"}, longint'(ppsOut), longint'(it.level));
        if (it.win)
          check(trig >= it.tgt && trig < it.tgt + INC, {it.req, " firing sample"}, trig, it.tgt);
      end
      lastPps = ppsOut;
    end
  end

  initial begin
    repeat (150000) @(posedge regClk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(posedge regClk);
    regRstN = 1; ptpRstN = 1;
    repeat (3) @(posedge regClk);
    monOn = 1;

    // R1 reset state
    regRead(2'd0, d); check(d == 0, "R1 sec", d, 0);
    regRead(2'd1, d); check(d == 0, "R1 ns/busy", d, 0);
    regRead(2'd2, d); check(d == 0, "R1 ctl", d, 0);
    check(ppsOut == 0 && irq == 0, "R1 outputs", {ppsOut, irq}, 0);

    // R10 / R5 register access and range
    regWrite(2'd0, 5);          regRead(2'd0, d); check(d == 5, "R10 sec", d, 5);
    regWrite(2'd1, 999999999);  regRead(2'd1, d); check(d == 999999999, "R5 max accepted", d, 999999999);
    regWrite(2'd1, 1000);       regRead(2'd1, d); check(d == 1000, "R10 ns", d, 1000);
    regWrite(2'd1, 1000000000); regRead(2'd1, d); check(d == 1000, "R5 over range ignored", d, 1000);
    regWrite(2'd2, 1);          regRead(2'd2, d); check(d == 1, "R10 enable", d, 1);

    // R2 R3 R7 start across a seconds rollover
    setTime(4 * GIGA + 999998000);
    expectEdge(1'b1, 5 * GIGA + 1000, 1'b1, "R7 start");
    issueCmd(3'b010);
    regRead(2'd1, d); check(d == 32'h8000_0000 + 1000, "R2 busy set", d, 32'h8000_0000 + 1000);
    regWrite(2'd1, 77);
    regWrite(2'd0, 9);
    waitIdle("R2 busy clears");
    regRead(2'd1, d); check(d == 1000, "R3 ns kept", d, 1000);
    regRead(2'd0, d); check(d == 5, "R3 sec kept", d, 5);
    waitPps(1'b1, 1500, "R6 start reached");

    // R9 interrupt and sticky status
    repeat (10) @(negedge regClk);
    check(irq == 1, "R9 irq raised", irq, 1);
    regRead(2'd2, d); check(d == 3, "R9 status set", d, 3);
    regWrite(2'd2, 3);
    regRead(2'd2, d); check(d == 1, "R9 status cleared", d, 1);
    check(irq == 0, "R9 irq low", irq, 0);

    // R8 single shot
    repeat (200) @(negedge regClk);
    regRead(2'd2, d); check(d == 1, "R8 no refire", d, 1);
    check(ppsOut == 1, "R8 level held", ppsOut, 1);

    // R4 other command codes
    issueCmd(3'b001);
    regRead(2'd1, d); check(d[31] == 0, "R4 no busy", longint'(d[31]), 0);
    issueCmd(3'b110);
    regRead(2'd1, d); check(d[31] == 0, "R4 no busy 110", longint'(d[31]), 0);
    repeat (50) @(negedge regClk);
    check(ppsOut == 1, "R4 pps unchanged", ppsOut, 1);

    // R7 stop with interrupt disabled
    regWrite(2'd2, 0);
    regWrite(2'd1, 500000);
    setTime(5 * GIGA + 495000);
    expectEdge(1'b0, 5 * GIGA + 500000, 1'b1, "R7 stop");
    issueCmd(3'b011);
    waitIdle("R2 busy clears stop");
    waitPps(1'b0, 2000, "R6 stop reached");
    repeat (10) @(negedge regClk);
    check(irq == 0, "R9 irq gated", irq, 0);
    regRead(2'd2, d); check(d == 2, "R9 status without enable", d, 2);

    // R6 target already in the past fires at once
    regWrite(2'd2, 2);
    regWrite(2'd0, 3);
    regWrite(2'd1, 0);
    expectEdge(1'b1, 3 * GIGA, 1'b0, "R6 past target");
    issueCmd(3'b010);
    waitIdle("R2 busy clears past");
    waitPps(1'b1, 100, "R6 past target fires");

    // R6 exact equality on the step grid
    regWrite(2'd0, 6);
    regWrite(2'd1, 7);
    setTime(6 * GIGA - 700);
    expectEdge(1'b0, 6 * GIGA + 7, 1'b1, "R6 exact");
    issueCmd(3'b011);
    waitIdle("R2 busy clears exact");
    waitPps(1'b0, 400, "R6 exact reached");

    repeat (20) @(negedge regClk);
    check(expQ.size() == 0, "R6 all edges seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule